// File: doc/BRIEF.md
# Single-Wire Debug Bit Engine

This block is the target side of a one-wire debug link. A single pseudo-open-drain line is shared with an external host that runs on its own clock. The host starts every bit, in either direction, by pulling the line low. The engine passes the line through a synchronizer and finds the host's falling edges. After each edge it either samples a bit the host is sending or drives a bit back onto the line. Bytes move most-significant bit first. Above this engine, a command layer sees a simple byte handshake. If the host stops making edges for too long, the engine raises a one-cycle abort and discards any partial byte.

The line is never raised passively. A low bit is driven low and then ended with a one-cycle active-high speedup pulse before release. A high bit gets only the speedup pulse. A released line idles high through the pad's pullup.

The sequencer has five states:
- `ST_IDLE` waits for a detected edge. From there it moves to `ST_RX_BIT` in receive mode. In transmit mode it moves to `ST_TX_LOW` for a 0 bit or to `ST_TX_WAIT` for a 1 bit.
- `ST_RX_BIT` returns to `ST_IDLE` at the sample cycle.
- `ST_TX_LOW` moves to `ST_SPEEDUP` at the end of the low phase.
- `ST_TX_WAIT` moves to `ST_SPEEDUP` just before the pulse cycle.
- `ST_SPEEDUP` always returns to `ST_IDLE`.
- An abort forces any state back to `ST_IDLE`.

Top module: `owdbg_bit_engine`

## Requirements
- R1: During and right after reset, `pad_oe`, `rx_valid`, `tx_done` and `timeout_abort` are low, and the engine is in receive mode.
- R2: `line_in` passes through a two-stage synchronizer. A bit starts only when a falling edge is detected, which means the previous synchronized sample was 1 and the current one is 0. No bit starts while the line stays high.
- R3: In receive mode the bit value is the synchronized line level 10 cycles after the detected edge. A host low lasting 13 cycles gives a 0, and a host low lasting 4 cycles gives a 1. In receive mode the pad is never driven.
- R4: Received bits are shifted in MSB first. After the eighth bit, `rx_valid` pulses high for exactly one cycle while `rx_data` holds the byte.
- R5: A transmitted 0 drives `pad_oe`=1, `pad_out`=0. This runs from the cycle after detection through detection cycle 12. Cycle 13 has `pad_oe`=1, `pad_out`=1, then the pad is released. Seen from the host, who starts low at host cycle 0, the low drive covers host cycles 3 to 14 and the pulse falls on cycle 15.
- R6: A transmitted 1 never drives low. It gives a single high pulse at detection cycle 6, which is host cycle 8.
- R7: A high on `tx_load` in `ST_IDLE` loads `tx_data` and selects transmit mode. Bits leave MSB first. After the eighth bit's speedup pulse, `tx_done` pulses for one cycle and the engine returns to receive mode.
- R8: An active-high drive (`pad_oe`=1 and `pad_out`=1) never lasts more than one cycle.
- R9: A detected edge clears an inactivity counter. When the counter reaches 512 cycles, `timeout_abort` pulses for one cycle, which is 515 host cycles after the host's low started. Edges that arrive 400 cycles apart never cause an abort.
- R10: An abort discards partial received bits and cancels a pending transmit. The next eight host bits are received as a clean byte in receive mode.
- R11: After reset, no abort is raised until the first falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Level read back from the debug line |
| pad_oe | output | 1 | Pad driver enable |
| pad_out | output | 1 | Level driven when `pad_oe` is high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` updated |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Load `tx_data` and enter transmit mode |
| tx_done | output | 1 | One-cycle pulse: eighth transmit bit finished |
| timeout_abort | output | 1 | One-cycle pulse: host inactivity timeout |

## Verification
The embedded assertions check the cycle-level rules on every clock:
- the speedup pulse is a single cycle;
- detected edges cannot repeat back to back;
- a low drive only starts right after a detected edge;
- the handshake and abort outputs are single-cycle pulses;
- an abort returns the sequencer to idle with the bit index and transmit mode cleared;
- the inactivity counter stays bounded.

Only the bench's host scenarios can show the rest. That covers exact drive windows seen from the host side, byte values sent and received MSB first, and the 515-cycle timeout latency. It also covers the keep-alive spacing, and recovery to clean receive after aborts in both directions.

// File: rtl/owdbg_pkg.sv
package owdbg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RX_BIT  = 3'd1,
        ST_TX_LOW  = 3'd2,
        ST_TX_WAIT = 3'd3,
        ST_SPEEDUP = 3'd4
    } bit_state_e;

endpackage

// File: rtl/owdbg_line_sync.sv
module owdbg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Reset to the idle-high level so no edge is seen out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];

    // R2: two detected edges can never be adjacent.
    p_fall_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

    // R2: a detected edge traces back to a low on the raw line STAGES cycles earlier.
    p_fall_from_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> ($past(line_i, STAGES) == 1'b0));

endmodule

// File: rtl/owdbg_timeout.sv
module owdbg_timeout #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    output logic abort_o
);
    localparam int TO_W = $clog2(LIMIT + 1);

    logic [TO_W-1:0] cnt_q;
    logic            abort_q;

    // Counter starts saturated: nothing to abort before the host's first edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= TO_W'(LIMIT);
            abort_q <= 1'b0;
        end else begin
            abort_q <= !fall_i && (cnt_q == TO_W'(LIMIT - 1));
            if (fall_i)
                cnt_q <= '0;
            else if (cnt_q != TO_W'(LIMIT))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign abort_o = abort_q;

    p_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TO_W'(LIMIT));

    p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    p_abort_at_saturation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_o) |-> (cnt_q == TO_W'(LIMIT)));

endmodule

// File: rtl/owdbg_bit_fsm.sv
module owdbg_bit_fsm
    import owdbg_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int BIT_CYCLES   = 16,
    parameter int SAMPLE_AT    = 10,
    parameter int LOW_END      = 12,
    parameter int ONE_PULSE_AT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              level_i,
    input  logic              abort_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              pad_oe_o,
    output logic              pad_out_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              tx_done_o
);
    localparam int CNT_W = $clog2(BIT_CYCLES);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    bit_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cyc_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              tx_mode_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              rx_valid_q;
    logic              tx_done_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall_i) begin
                    if (!tx_mode_q)                state_d = ST_RX_BIT;
                    else if (shift_q[DATA_W-1])    state_d = ST_TX_WAIT;
                    else                           state_d = ST_TX_LOW;
                end
            end
            ST_RX_BIT:  if (cyc_q == CNT_W'(SAMPLE_AT))        state_d = ST_IDLE;
            ST_TX_LOW:  if (cyc_q == CNT_W'(LOW_END))          state_d = ST_SPEEDUP;
            ST_TX_WAIT: if (cyc_q == CNT_W'(ONE_PULSE_AT - 1)) state_d = ST_SPEEDUP;
            ST_SPEEDUP: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (abort_i) state_d = ST_IDLE;
    end

    // Bit-time cycle counter: 0 on the detection cycle, counts while busy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cyc_q <= '0;
        else if (state_q == ST_IDLE && fall_i)   cyc_q <= CNT_W'(1);
        else if (state_q != ST_IDLE)             cyc_q <= cyc_q + 1'b1;
    end

    // Shift register, bit index, mode and byte handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q  <= '0;
            shift_q    <= '0;
            tx_mode_q  <= 1'b0;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
            tx_done_q  <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            tx_done_q  <= 1'b0;
            if (abort_i) begin
                bit_idx_q <= '0;
                shift_q   <= '0;
                tx_mode_q <= 1'b0;
            end else begin
                if (state_q == ST_IDLE && tx_load_i) begin
                    shift_q   <= tx_data_i;
                    tx_mode_q <= 1'b1;
                    bit_idx_q <= '0;
                end
                if (state_q == ST_RX_BIT && cyc_q == CNT_W'(SAMPLE_AT)) begin
                    shift_q <= {shift_q[DATA_W-2:0], level_i};
                    if (bit_idx_q == LAST_IDX) begin
                        rx_data_q  <= {shift_q[DATA_W-2:0], level_i};
                        rx_valid_q <= 1'b1;
                        bit_idx_q  <= '0;
                    end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
                if (state_q == ST_SPEEDUP) begin
                    shift_q <= {shift_q[DATA_W-2:0], 1'b0};
                    if (bit_idx_q == LAST_IDX) begin
                        tx_done_q <= 1'b1;
                        tx_mode_q <= 1'b0;
                        bit_idx_q <= '0;
                    end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
            end
        end
    end

    // Pad outputs
    always_comb begin
        pad_oe_o  = 1'b0;
        pad_out_o = 1'b0;
        unique case (state_q)
            ST_TX_LOW:  begin pad_oe_o = 1'b1; pad_out_o = 1'b0; end
            ST_SPEEDUP: begin pad_oe_o = 1'b1; pad_out_o = 1'b1; end
            default:    begin pad_oe_o = 1'b0; pad_out_o = 1'b0; end
        endcase
    end

    assign rx_data_o  = rx_data_q;
    assign rx_valid_o = rx_valid_q;
    assign tx_done_o  = tx_done_q;

    p_speedup_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe_o && pad_out_o) |=> !(pad_oe_o && pad_out_o));

    p_low_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe_o && !pad_out_o) |-> $past(fall_i));

    p_rx_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |=> !tx_done_o);

    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (state_q == ST_IDLE && bit_idx_q == '0 && !tx_mode_q));

endmodule

// File: rtl/owdbg_bit_engine.sv
module owdbg_bit_engine #(
    parameter int DATA_W         = 8,
    parameter int BIT_CYCLES     = 16,
    parameter int SAMPLE_AT      = 10,
    parameter int LOW_END        = 12,
    parameter int ONE_PULSE_AT   = 6,
    parameter int TIMEOUT_CYCLES = 512,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              pad_oe,
    output logic              pad_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_done,
    output logic              timeout_abort
);
    logic level_s;
    logic fall_s;
    logic abort_s;

    owdbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_in),
        .level_o (level_s),
        .fall_o  (fall_s)
    );

    owdbg_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall_s),
        .abort_o (abort_s)
    );

    owdbg_bit_fsm #(
        .DATA_W       (DATA_W),
        .BIT_CYCLES   (BIT_CYCLES),
        .SAMPLE_AT    (SAMPLE_AT),
        .LOW_END      (LOW_END),
        .ONE_PULSE_AT (ONE_PULSE_AT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall_s),
        .level_i    (level_s),
        .abort_i    (abort_s),
        .tx_data_i  (tx_data),
        .tx_load_i  (tx_load),
        .pad_oe_o   (pad_oe),
        .pad_out_o  (pad_out),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .tx_done_o  (tx_done)
    );

    assign timeout_abort = abort_s;

endmodule

// File: tb/owdbg_bit_engine_test.sv
module owdbg_bit_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       line_in;
    logic       pad_oe, pad_out, rx_valid, tx_done, timeout_abort;
    logic [7:0] rx_data;

    int tests = 0;
    int fails = 0;
    int rx_cnt = 0;
    int done_cnt = 0;
    int abort_cnt = 0;
    int low_drive_cnt = 0;
    int hi_run = 0;
    int hi_run_max = 0;
    logic [7:0] rx_last = 8'h00;
    bit finished = 1'b0;

    // Wired line: host low wins, else target drive, else pullup.
    assign line_in = host_low ? 1'b0 : (pad_oe ? pad_out : 1'b1);

    always #5 clk = ~clk;

    owdbg_bit_engine uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_in),
        .pad_oe        (pad_oe),
        .pad_out       (pad_out),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .tx_data       (tx_data),
        .tx_load       (tx_load),
        .tx_done       (tx_done),
        .timeout_abort (timeout_abort)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
            if (tx_done) done_cnt++;
            if (timeout_abort) abort_cnt++;
            if (pad_oe && !pad_out) low_drive_cnt++;
            if (pad_oe && pad_out) hi_run++; else hi_run = 0;
            if (hi_run > hi_run_max) hi_run_max = hi_run;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        int low_len;
        low_len = b ? 4 : 13;
        @(negedge clk) host_low = 1'b1;
        repeat (low_len) @(negedge clk);
        host_low = 1'b0;
        repeat (20 - low_len) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic read_bit(output logic b);
        @(negedge clk) host_low = 1'b1;
        repeat (4) @(negedge clk);
        host_low = 1'b0;
        repeat (6) @(negedge clk);
        b = line_in;
        repeat (10) @(negedge clk);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            v[i] = b;
        end
    endtask

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk);
        tx_data = v;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // One host-started bit; records the pad drive pattern per host cycle.
    task automatic probe_bit(output int low_first, output int low_count,
                             output int high_at, output int high_count);
        low_first = 0; low_count = 0; high_at = 0; high_count = 0;
        @(negedge clk) host_low = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (pad_oe && !pad_out) begin
                if (low_count == 0) low_first = k;
                low_count++;
            end
            if (pad_oe && pad_out) begin
                high_at = k;
                high_count++;
            end
            if (k == 4) host_low = 1'b0;
        end
    endtask

    // Host edge, then silence; returns host cycle of first abort (0 if none).
    task automatic quiet_after_edge(output int seen_at);
        seen_at = 0;
        @(negedge clk) host_low = 1'b1;
        for (int k = 1; k <= 700; k++) begin
            @(negedge clk);
            if (k == 4) host_low = 1'b0;
            if (timeout_abort && seen_at == 0) seen_at = k;
        end
    endtask

    // dir bit (1 = target transmits), byte value
    localparam logic [8:0] VEC [0:7] = '{
        {1'b0, 8'hA5}, {1'b0, 8'h01}, {1'b0, 8'h80}, {1'b0, 8'hFF},
        {1'b1, 8'h3C}, {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b1, 8'h96}
    };

    initial begin
        int lf, lc, ha, hc, at, base;
        logic [7:0] got;
        logic b;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(pad_oe), 0, "pad_oe in reset");
        check("R1", int'(rx_valid | tx_done | timeout_abort), 0, "pulses in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(pad_oe), 0, "pad_oe after reset");

        // R11 / R2: idle-high line for 600 cycles: no abort, no bit starts
        repeat (600) @(negedge clk);
        check("R11", abort_cnt, 0, "abort before first edge");
        check("R2", rx_cnt + low_drive_cnt, 0, "activity without edge");

        // Vector table: R3 R4 receive, R7 transmit
        for (int v = 0; v < 8; v++) begin
            if (VEC[v][8] == 1'b0) begin
                base = rx_cnt;
                lc = low_drive_cnt;
                send_byte(VEC[v][7:0]);
                check("R4", rx_cnt - base, 1, "rx_valid pulses per byte");
                check("R4", int'(rx_last), int'(VEC[v][7:0]), "received byte MSB first");
                check("R3", low_drive_cnt - lc, 0, "no low drive in receive");
            end else begin
                base = done_cnt;
                load_tx(VEC[v][7:0]);
                read_byte(got);
                check("R7", int'(got), int'(VEC[v][7:0]), "transmitted byte MSB first");
                check("R7", done_cnt - base, 1, "tx_done pulses per byte");
            end
        end

        // R5: transmit 0 drive window; R6: transmit 1 pulse only
        load_tx(8'h40);
        probe_bit(lf, lc, ha, hc);
        check("R5", lf, 3, "first low-drive host cycle");
        check("R5", lc, 12, "low-drive length");
        check("R5", ha, 15, "speedup host cycle after low");
        check("R5", hc, 1, "speedup count after low");
        probe_bit(lf, lc, ha, hc);
        check("R6", lc, 0, "no low drive for a 1");
        check("R6", ha, 8, "speedup host cycle for a 1");
        check("R6", hc, 1, "speedup count for a 1");
        base = done_cnt;
        for (int i = 0; i < 6; i++) read_bit(b);
        check("R7", done_cnt - base, 1, "done after remaining bits");

        // R9: keep-alive with edges 400 cycles apart
        base = abort_cnt;
        for (int i = 0; i < 3; i++) begin
            send_bit(1'b1);
            repeat (380) @(negedge clk);
        end
        check("R9", abort_cnt - base, 0, "abort despite keep-alive");

        // R9: timeout latency (edge + 2 sync + 512 count + 1 register)
        quiet_after_edge(at);
        check("R9", at, 515, "abort host cycle");
        check("R9", abort_cnt - base, 1, "single abort pulse");

        // R10: partial receive (4 bits) discarded by the abort above
        base = rx_cnt;
        send_byte(8'h3C);
        check("R10", rx_cnt - base, 1, "byte after rx abort");
        check("R10", int'(rx_last), 8'h3C, "clean byte after rx abort");

        // R10: pending transmit cancelled by an abort
        load_tx(8'h0F);
        read_bit(b);
        read_bit(b);
        quiet_after_edge(at);
        check("R10", int'(at != 0), 1, "abort during transmit");
        base = done_cnt;
        lc = low_drive_cnt;
        send_byte(8'h5A);
        check("R10", int'(rx_last), 8'h5A, "receive mode after tx abort");
        check("R10", done_cnt - base, 0, "no tx_done after tx abort");
        check("R10", low_drive_cnt - lc, 0, "no drive after tx abort");

        // R8: speedup never longer than one cycle
        check("R8", hi_run_max, 1, "longest active-high run");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule